// File: doc/BRIEF.md
# Dual-Port Word Memory with Cross-Port Mailbox Interrupts

This block is a synchronous memory of 4K sixteen-bit words that two independent agents, called left and right, can access at the same time. Each side has its own active-low select, a direction input (high reads, low writes), an active-low output enable, active-low enables for the upper and lower byte, a 12-bit address, and write and read data buses. The read bus is tri-state in the system. Here it is modelled as registered data plus a per-byte drive-enable pair that tells the pad ring which bytes to drive.

The two highest addresses also act as doorbells between the agents. When the left side writes the top word, the right side's active-low interrupt output goes low. When the right side writes the word just below it, the left side's interrupt goes low. Each interrupt is cleared when its owner reads its own doorbell word. The doorbell words still hold data, so the sender can leave a message there and the receiver reads it back while acknowledging the interrupt.

Top module: `dpram_mailbox`

## Requirements
- R1: A side whose select is high, or whose two byte enables are both high, drives no byte on the clock after and stores nothing.
- R2: A write happens when select is low and direction is low. Upper enable gates bits 15..8 and lower enable gates bits 7..0. The output enable has no effect on a write.
- R3: A read happens when select is low, direction is high and output enable is low. On the next clock, drive-enable bit 1 (upper byte) and bit 0 (lower byte) follow the byte enables. Enabled bytes carry the stored word and undriven bytes read as zero.
- R4: While the output enable is high, a side with direction high drives no byte.
- R5: A left write to address 0xFFF pulls the right interrupt low on the next clock. A right read of 0xFFF returns it high on the next clock.
- R6: A right write to address 0xFFE pulls the left interrupt low on the next clock. A left read of 0xFFE returns it high on the next clock.
- R7: Doorbell addresses store data like any other word, so the receiver reads back the message the sender wrote.
- R8: When both sides write the same address in one cycle, the left data wins in each byte both sides enabled. A byte that only one side enabled takes that side's data.
- R9: After reset both interrupt outputs are high and no byte is driven.
- R10: If one cycle both raises and clears the same interrupt, the interrupt ends up low.
- R11: A read in the same cycle as a write to that address by the other side returns the word as it was before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_cs_n | input | 1 | Left select, active low |
| l_we_n | input | 1 | Left direction: 1 read, 0 write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_ub_n | input | 1 | Left upper byte enable, active low |
| l_lb_n | input | 1 | Left lower byte enable, active low |
| l_addr | input | 12 | Left word address |
| l_wdata | input | 16 | Left write data |
| l_rdata | output | 16 | Left read data, registered |
| l_drv_en | output | 2 | Left byte drive enables {upper, lower} |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_cs_n | input | 1 | Right select, active low |
| r_we_n | input | 1 | Right direction: 1 read, 0 write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_ub_n | input | 1 | Right upper byte enable, active low |
| r_lb_n | input | 1 | Right lower byte enable, active low |
| r_addr | input | 12 | Right word address |
| r_wdata | input | 16 | Right write data |
| r_rdata | output | 16 | Right read data, registered |
| r_drv_en | output | 2 | Right byte drive enables {upper, lower} |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
Every result is due exactly one clock after the edge that samples its request. This covers read data, drive enables, interrupt set and interrupt clear. A stored word becomes visible to a read issued on the following cycle. The bench drives inputs on the falling edge and lets the rising edge sample them. Its reference model is updated with those same inputs, and the outputs are compared one nanosecond after that rising edge. Reset release passes through two synchronizing flops, so the bench idles through several cycles before the first access.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int DATA_W = LANE_W * LANES;

  // Decoded request of one side for one cycle.
  typedef struct packed {
    logic             rd;
    logic             wr;
    logic [LANES-1:0] lanes;
  } dpm_op_t;
endpackage

// File: rtl/dpm_port_dec.sv
module dpm_port_dec
  import dpm_pkg::*;
(
  input  logic    cs_n,
  input  logic    we_n,
  input  logic    oe_n,
  input  logic    ub_n,
  input  logic    lb_n,
  output dpm_op_t op
);
  logic sel;

  always_comb begin
    sel      = !cs_n && !(ub_n && lb_n);
    op.lanes = {!ub_n, !lb_n};
    op.wr    = sel && !we_n;
    op.rd    = sel && we_n && !oe_n;
  end
endmodule

// File: rtl/dpm_store.sv
module dpm_store
  import dpm_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpm_op_t           op    [2],
  input  logic [ADDR_W-1:0] addr  [2],
  input  logic [DATA_W-1:0] wdata [2],
  output logic [DATA_W-1:0] rdata [2],
  output logic [LANES-1:0]  drv   [2]
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_nxt [2];
  logic [LANES-1:0]  drv_nxt   [2];
  logic              rd_en     [2];

  // Right side first, left side last: left wins on shared bytes.
  always_ff @(posedge clk) begin
    for (int p = 1; p >= 0; p--) begin
      if (op[p].wr) begin
        for (int b = 0; b < LANES; b++) begin
          if (op[p].lanes[b])
            mem[addr[p]][b*LANE_W +: LANE_W] <= wdata[p][b*LANE_W +: LANE_W];
        end
      end
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    always_comb begin
      drv_nxt[p] = op[p].rd ? op[p].lanes : '0;
      rd_en[p]   = op[p].rd || (drv[p] != '0);
      for (int b = 0; b < LANES; b++)
        rdata_nxt[p][b*LANE_W +: LANE_W] = drv_nxt[p][b]
          ? mem[addr[p]][b*LANE_W +: LANE_W] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdata[p] <= '0;
        drv[p]   <= '0;
      end else if (rd_en[p]) begin
        rdata[p] <= rdata_nxt[p];
        drv[p]   <= drv_nxt[p];
      end
    end
  end
endmodule

// File: rtl/dpm_mailbox.sv
module dpm_mailbox
  import dpm_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpm_op_t           op    [2],
  input  logic [ADDR_W-1:0] addr  [2],
  output logic              irq_n [2]
);
  for (genvar p = 0; p < 2; p++) begin : g_box
    // Side 0 (left) owns the word below the top; side 1 owns the top word.
    localparam logic [ADDR_W-1:0] BOX = (p == 0) ? {{(ADDR_W-1){1'b1}}, 1'b0}
                                                 : {ADDR_W{1'b1}};
    localparam int Q = 1 - p;

    logic flag, flag_nxt, flag_en, set, clr;

    always_comb begin
      set      = op[Q].wr && (addr[Q] == BOX);
      clr      = op[p].rd && (addr[p] == BOX);
      flag_en  = set || clr;
      flag_nxt = set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag <= 1'b0;
      else if (flag_en) flag <= flag_nxt;
    end

    assign irq_n[p] = !flag;
  end
endmodule

// File: rtl/dpram_mailbox.sv
module dpram_mailbox
  import dpm_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_cs_n,
  input  logic              l_we_n,
  input  logic              l_oe_n,
  input  logic              l_ub_n,
  input  logic              l_lb_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic [LANES-1:0]  l_drv_en,
  output logic              l_irq_n,
  input  logic              r_cs_n,
  input  logic              r_we_n,
  input  logic              r_oe_n,
  input  logic              r_ub_n,
  input  logic              r_lb_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic [LANES-1:0]  r_drv_en,
  output logic              r_irq_n
);
  logic              rst_m, rst_q;
  logic              cs_n [2], we_n [2], oe_n [2], ub_n [2], lb_n [2];
  logic [ADDR_W-1:0] addr [2];
  logic [DATA_W-1:0] wdata [2], rdata [2];
  logic [LANES-1:0]  drv [2];
  logic              irq_n [2];
  dpm_op_t           op [2];

  // Assert asynchronously, release on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  always_comb begin
    cs_n[0] = l_cs_n;  we_n[0] = l_we_n;  oe_n[0] = l_oe_n;
    ub_n[0] = l_ub_n;  lb_n[0] = l_lb_n;  addr[0] = l_addr;  wdata[0] = l_wdata;
    cs_n[1] = r_cs_n;  we_n[1] = r_we_n;  oe_n[1] = r_oe_n;
    ub_n[1] = r_ub_n;  lb_n[1] = r_lb_n;  addr[1] = r_addr;  wdata[1] = r_wdata;
  end

  for (genvar p = 0; p < 2; p++) begin : g_dec
    dpm_port_dec u_dec (
      .cs_n (cs_n[p]), .we_n (we_n[p]), .oe_n (oe_n[p]),
      .ub_n (ub_n[p]), .lb_n (lb_n[p]), .op (op[p])
    );
  end

  dpm_store #(.ADDR_W(ADDR_W)) u_store (
    .clk (clk), .rst_n (rst_q), .op (op), .addr (addr),
    .wdata (wdata), .rdata (rdata), .drv (drv)
  );

  dpm_mailbox #(.ADDR_W(ADDR_W)) u_mbox (
    .clk (clk), .rst_n (rst_q), .op (op), .addr (addr), .irq_n (irq_n)
  );

  assign l_rdata  = rdata[0];
  assign r_rdata  = rdata[1];
  assign l_drv_en = drv[0];
  assign r_drv_en = drv[1];
  assign l_irq_n  = irq_n[0];
  assign r_irq_n  = irq_n[1];
endmodule

// File: rtl/dpm_checker.sv
module dpm_checker #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_q,
  input logic              l_cs_n, l_we_n, l_oe_n, l_ub_n, l_lb_n,
  input logic [ADDR_W-1:0] l_addr,
  input logic [1:0]        l_drv_en,
  input logic              l_irq_n,
  input logic              r_cs_n, r_we_n, r_oe_n, r_ub_n, r_lb_n,
  input logic [ADDR_W-1:0] r_addr,
  input logic [1:0]        r_drv_en,
  input logic              r_irq_n
);
  localparam logic [ADDR_W-1:0] TOP  = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] NEXT = {{(ADDR_W-1){1'b1}}, 1'b0};

  logic l_wr, r_wr, l_rd, r_rd;
  assign l_wr = !l_cs_n && !l_we_n && !(l_ub_n && l_lb_n);
  assign r_wr = !r_cs_n && !r_we_n && !(r_ub_n && r_lb_n);
  assign l_rd = !l_cs_n && l_we_n && !l_oe_n && !(l_ub_n && l_lb_n);
  assign r_rd = !r_cs_n && r_we_n && !r_oe_n && !(r_ub_n && r_lb_n);

  a_r1_left_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_q)
    (l_cs_n || (l_ub_n && l_lb_n)) |=> (l_drv_en == 2'b00));
  a_r1_right_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_q)
    (r_cs_n || (r_ub_n && r_lb_n)) |=> (r_drv_en == 2'b00));
  a_r4_oe_off_quiet: assert property (@(posedge clk) disable iff (!rst_q)
    (l_oe_n && r_oe_n) |=> (l_drv_en == 2'b00 && r_drv_en == 2'b00));
  a_r3_lane_drive: assert property (@(posedge clk) disable iff (!rst_q)
    l_rd |=> (l_drv_en == {!$past(l_ub_n), !$past(l_lb_n)}));
  a_r5_right_irq_set: assert property (@(posedge clk) disable iff (!rst_q)
    (l_wr && l_addr == TOP) |=> !r_irq_n);
  a_r5_right_irq_clear: assert property (@(posedge clk) disable iff (!rst_q)
    (r_rd && r_addr == TOP && !(l_wr && l_addr == TOP)) |=> r_irq_n);
  a_r6_left_irq_set: assert property (@(posedge clk) disable iff (!rst_q)
    (r_wr && r_addr == NEXT) |=> !l_irq_n);
  a_r6_left_irq_clear: assert property (@(posedge clk) disable iff (!rst_q)
    (l_rd && l_addr == NEXT && !(r_wr && r_addr == NEXT)) |=> l_irq_n);
endmodule

bind dpram_mailbox dpm_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk (clk), .rst_q (rst_q),
  .l_cs_n (l_cs_n), .l_we_n (l_we_n), .l_oe_n (l_oe_n), .l_ub_n (l_ub_n),
  .l_lb_n (l_lb_n), .l_addr (l_addr), .l_drv_en (l_drv_en), .l_irq_n (l_irq_n),
  .r_cs_n (r_cs_n), .r_we_n (r_we_n), .r_oe_n (r_oe_n), .r_ub_n (r_ub_n),
  .r_lb_n (r_lb_n), .r_addr (r_addr), .r_drv_en (r_drv_en), .r_irq_n (r_irq_n)
);

// File: tb/tb_dpram_mailbox.sv
module tb_dpram_mailbox;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_cs_n, l_we_n, l_oe_n, l_ub_n, l_lb_n, r_cs_n, r_we_n, r_oe_n, r_ub_n, r_lb_n;
  logic [11:0] l_addr, r_addr;
  logic [15:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic [1:0]  l_drv_en, r_drv_en;
  logic        l_irq_n, r_irq_n;

  int checks = 0, errors = 0;
  string cur_req = "R9";
  logic [15:0] mem [int];
  logic [1:0]  e_drv [2];
  logic [15:0] e_dat [2];
  logic        e_irq [2];

  always #2 clk = ~clk;

  dpram_mailbox dut (.*);

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic set_l(bit cs, bit we, bit oe, bit ub, bit lb, int a, int d);
    l_cs_n = cs; l_we_n = we; l_oe_n = oe; l_ub_n = ub; l_lb_n = lb;
    l_addr = a[11:0]; l_wdata = d[15:0];
  endtask
  task automatic set_r(bit cs, bit we, bit oe, bit ub, bit lb, int a, int d);
    r_cs_n = cs; r_we_n = we; r_oe_n = oe; r_ub_n = ub; r_lb_n = lb;
    r_addr = a[11:0]; r_wdata = d[15:0];
  endtask
  task automatic idle();
    set_l(1, 1, 1, 1, 1, 0, 0);
    set_r(1, 1, 1, 1, 1, 0, 0);
  endtask

  // Advance one clock: update the reference model with the sampled inputs, then compare.
  task automatic step();
    logic [15:0] old;
    bit rd [2], wr [2];
    logic [1:0] ln [2];
    int a [2];
    logic [15:0] wd [2];
    bit set_l_irq, clr_l_irq, set_r_irq, clr_r_irq;
    @(posedge clk);
    #1;
    ln[0] = {!l_ub_n, !l_lb_n}; ln[1] = {!r_ub_n, !r_lb_n};
    a[0] = int'(l_addr); a[1] = int'(r_addr);
    wd[0] = l_wdata; wd[1] = r_wdata;
    wr[0] = !l_cs_n && !l_we_n && ln[0] != 0;
    wr[1] = !r_cs_n && !r_we_n && ln[1] != 0;
    rd[0] = !l_cs_n && l_we_n && !l_oe_n && ln[0] != 0;
    rd[1] = !r_cs_n && r_we_n && !r_oe_n && ln[1] != 0;
    for (int p = 0; p < 2; p++) begin
      old = mem.exists(a[p]) ? mem[a[p]] : 16'hxxxx;
      e_drv[p] = rd[p] ? ln[p] : 2'b00;
      e_dat[p] = {e_drv[p][1] ? old[15:8] : 8'h00, e_drv[p][0] ? old[7:0] : 8'h00};
    end
    for (int p = 1; p >= 0; p--) begin
      if (wr[p]) begin
        old = mem.exists(a[p]) ? mem[a[p]] : 16'hxxxx;
        if (ln[p][1]) old[15:8] = wd[p][15:8];
        if (ln[p][0]) old[7:0]  = wd[p][7:0];
        mem[a[p]] = old;
      end
    end
    set_l_irq = wr[1] && a[1] == 'hFFE; clr_l_irq = rd[0] && a[0] == 'hFFE;
    set_r_irq = wr[0] && a[0] == 'hFFF; clr_r_irq = rd[1] && a[1] == 'hFFF;
    if (set_l_irq) e_irq[0] = 0; else if (clr_l_irq) e_irq[0] = 1;
    if (set_r_irq) e_irq[1] = 0; else if (clr_r_irq) e_irq[1] = 1;
    check("l_drv_en", 32'(l_drv_en), 32'(e_drv[0]));
    check("r_drv_en", 32'(r_drv_en), 32'(e_drv[1]));
    check("l_irq_n", 32'(l_irq_n), 32'(e_irq[0]));
    check("r_irq_n", 32'(r_irq_n), 32'(e_irq[1]));
    if (!$isunknown(e_dat[0])) check("l_rdata", 32'(l_rdata), 32'(e_dat[0]));
    if (!$isunknown(e_dat[1])) check("r_rdata", 32'(r_rdata), 32'(e_dat[1]));
    @(negedge clk);
  endtask

  initial begin
    #80000;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    e_irq[0] = 1; e_irq[1] = 1; e_drv[0] = 0; e_drv[1] = 0;
    idle();
    repeat (3) @(negedge clk);
    cur_req = "R9";
    check("l_irq_n reset", 32'(l_irq_n), 1);
    check("r_irq_n reset", 32'(r_irq_n), 1);
    check("l_drv_en reset", 32'(l_drv_en), 0);
    rst_n = 1'b1;
    repeat (5) step();

    cur_req = "R2";
    set_l(0, 0, 0, 0, 0, 'h100, 'hA5C3); step();
    set_l(0, 0, 1, 0, 0, 'h101, 'h0F0F); step();
    idle(); set_r(0, 0, 0, 0, 1, 'h100, 'h77EE); step();
    set_r(0, 0, 1, 1, 0, 'h101, 'h1122); step();
    cur_req = "R3";
    idle(); set_r(0, 1, 0, 0, 0, 'h100, 0); step();
    set_r(0, 1, 0, 1, 0, 'h101, 0); step();
    set_l(0, 1, 0, 0, 1, 'h101, 0); step();
    idle(); step();
    cur_req = "R1";
    set_l(1, 0, 0, 0, 0, 'h100, 'hFFFF); set_r(0, 0, 0, 1, 1, 'h101, 'hFFFF); step();
    set_l(1, 1, 0, 0, 0, 'h100, 0); set_r(0, 1, 0, 1, 1, 'h101, 0); step();
    set_l(0, 1, 0, 0, 0, 'h100, 0); set_r(0, 1, 0, 0, 0, 'h101, 0); step();
    cur_req = "R4";
    set_l(0, 1, 1, 0, 0, 'h100, 0); set_r(0, 1, 1, 0, 0, 'h101, 0); step();
    idle(); step();

    cur_req = "R5";
    set_l(0, 0, 0, 0, 0, 'hFFF, 'h1234); step();
    idle(); step();
    cur_req = "R7";
    set_r(0, 1, 0, 0, 0, 'hFFF, 0); step();
    idle(); step();
    cur_req = "R6";
    set_r(0, 0, 1, 0, 0, 'hFFE, 'hBEEF); step();
    set_r(0, 0, 0, 0, 0, 'hFFF, 'h5555); idle(); step();
    set_l(0, 1, 0, 0, 0, 'hFFE, 0); step();
    idle(); step();

    cur_req = "R10";
    set_l(0, 0, 0, 0, 0, 'hFFF, 'h0001); step();
    set_l(0, 0, 0, 0, 0, 'hFFF, 'h0002); set_r(0, 1, 0, 0, 0, 'hFFF, 0); step();
    idle(); step();
    set_r(0, 1, 0, 0, 0, 'hFFF, 0); step();
    idle(); step();

    cur_req = "R8";
    set_l(0, 0, 0, 0, 0, 'h200, 'h1111); set_r(0, 0, 0, 0, 0, 'h200, 'h2222); step();
    idle(); set_r(0, 1, 0, 0, 0, 'h200, 0); step();
    set_l(0, 0, 0, 0, 1, 'h200, 'hAB00); set_r(0, 0, 0, 1, 0, 'h200, 'h00CD); step();
    idle(); set_l(0, 1, 0, 0, 0, 'h200, 0); step();

    cur_req = "R11";
    set_l(0, 0, 0, 0, 0, 'h200, 'h9999); set_r(0, 1, 0, 0, 0, 'h200, 0); step();
    idle(); set_r(0, 1, 0, 0, 0, 'h200, 0); step();
    idle(); repeat (2) step();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule